// File: doc/BRIEF.md
# Retrain Handshake Controller

This block supervises resynchronisation between two duplex modems sharing a line. It watches the receiver's loss-of-equalisation flag and the remote-training detector, and it watches the request-to-send level from the terminal. From these it decides when the local transmitter must send a training sequence. It issues a single-cycle start pulse to the local training generator. The generator answers with a done pulse when its final segment has been sent.

An initiating modem then waits for the far end's sequence. It sends a new sequence if the far end stays silent for a timeout, or if the receiver fails to lock onto what arrived. A modem that only answers and then locks correctly sends exactly one sequence. The ready-for-sending output is held off while a handshake runs. After request-to-send rises, the output comes on once a selectable short or long delay has elapsed. All delays and the timeout are counted in millisecond ticks and are set by parameters.

Top module: `retrain_ctrl`

## Requirements
- R1: After reset, start_o and rfs_o are 0 and the controller is idle.
- R2: When idle, a rising edge of loe_i gives a start_o pulse after the next clock edge, and the controller then expects a remote sequence.
- R3: When idle with carrier_mode_i=1, a rising edge of rts_i gives a start_o pulse after the next clock edge. With carrier_mode_i=0 the edge starts no training.
- R4: When idle, a rising edge of remote_i gives a start_o pulse after the next clock edge, whatever the level of rts_i.
- R5: An initiator that has seen train_done_i and has had no completed remote sequence sends a new start_o pulse TIMEOUT_TICKS ticks after done.
- R6: A remote sequence ends when remote_i falls. If it ends while rx_sync_i=0 during a handshake, a new training sequence is started.
- R7: If a remote sequence ends with rx_sync_i=1, the handshake closes once the local training is done, and no further start_o is issued.
- R8: rfs_o is 0 while training is running or a remote sequence is awaited, and it is 0 in the cycle that start_o is 1.
- R9: When idle with rts_i held high, rfs_o turns on after SHORT_TICKS+1 ticked edges if long_dly_i=0, or after LONG_TICKS+1 ticked edges if long_dly_i=1. Before that it stays off.
- R10: When rts_i is 0 before a clock edge, rfs_o is 0 after that edge.
- R11: If train_done_i and a failed remote end arrive in the same cycle, the controller restarts training rather than entering the wait.
- R12: A rising edge of loe_i while training is running issues no extra start_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle millisecond tick |
| rts_i | input | 1 | Request-to-send level |
| loe_i | input | 1 | Local loss-of-equalisation flag |
| remote_i | input | 1 | High while a remote training sequence is received |
| rx_sync_i | input | 1 | Receiver synchronised flag |
| carrier_mode_i | input | 1 | 1: request-to-send controls the carrier |
| long_dly_i | input | 1 | 1: use the long ready-for-sending delay |
| train_done_i | input | 1 | Local training generator finished its last segment |
| start_o | output | 1 | One-cycle start pulse to the training generator |
| rfs_o | output | 1 | Ready-for-sending |

## Verification
Two functions can meet in one cycle: the local generator can report done in the same cycle that the remote sequence ends without lock. The bench provokes this by driving train_done_i high and lowering remote_i with rx_sync_i low at the same falling edge. It then expects a start pulse after the next edge, not silence while a wait runs. A second overlap is a loss-of-equalisation edge that arrives while training is already running. There the bench counts start pulses and expects no extra one.

// File: rtl/retrain_pkg.sv
package retrain_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRAIN = 2'd1,
    ST_WAIT  = 2'd2
  } rt_state_e;
endpackage

// File: rtl/rt_edge_det.sv
module rt_edge_det #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= lvl_i[i];
    end
    assign rise_o[i] = lvl_i[i] & ~prev_q;
    assign fall_o[i] = ~lvl_i[i] & prev_q;
  end
endmodule

// File: rtl/rt_tick_cnt.sv
module rt_tick_cnt #(
  parameter int MAX = 15,
  localparam int W  = $clog2(MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_o <= '0;
    else if (clr_i)                       cnt_o <= '0;
    else if (tick_i && cnt_o < W'(MAX))   cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/rt_fsm.sv
module rt_fsm
  import retrain_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      loe_rise_i,
  input  logic      rts_rise_i,
  input  logic      rem_rise_i,
  input  logic      rem_fall_i,
  input  logic      carrier_i,
  input  logic      rx_sync_i,
  input  logic      train_done_i,
  input  logic      timeout_i,
  output logic      start_o,
  output rt_state_e state_o,
  output logic      nxt_idle_o
);
  rt_state_e state_q, state_d;
  logic expect_q, expect_d;
  logic ok_q, ok_d, fail_q, fail_d;
  logic start_d, restart;

  always_comb begin
    state_d  = state_q;
    expect_d = expect_q;
    ok_d     = ok_q   | (rem_fall_i &  rx_sync_i);
    fail_d   = fail_q | (rem_fall_i & ~rx_sync_i);
    start_d  = 1'b0;
    restart  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (loe_rise_i || rem_rise_i || (rts_rise_i && carrier_i)) begin
          start_d  = 1'b1;
          state_d  = ST_TRAIN;
          expect_d = loe_rise_i | rem_rise_i;
          ok_d     = 1'b0;
          fail_d   = 1'b0;
        end
      end
      ST_TRAIN: begin
        if (rem_rise_i) expect_d = 1'b1;
        if (train_done_i) begin
          if (!expect_d)   state_d = ST_IDLE;
          else if (fail_d) restart = 1'b1;  // failure wins over entering wait
          else if (ok_d)   state_d = ST_IDLE;
          else             state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (fail_d)         restart = 1'b1;
        else if (ok_d)      state_d = ST_IDLE;
        else if (timeout_i) restart = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    if (restart) begin
      start_d  = 1'b1;
      state_d  = ST_TRAIN;
      expect_d = 1'b1;
      ok_d     = 1'b0;
      fail_d   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      expect_q <= 1'b0;
      ok_q     <= 1'b0;
      fail_q   <= 1'b0;
      start_o  <= 1'b0;
    end else begin
      state_q  <= state_d;
      expect_q <= expect_d;
      ok_q     <= ok_d;
      fail_q   <= fail_d;
      start_o  <= start_d;
    end
  end

  assign state_o    = state_q;
  assign nxt_idle_o = (state_d == ST_IDLE);
endmodule

// File: rtl/retrain_ctrl.sv
module retrain_ctrl
  import retrain_pkg::*;
#(
  parameter int SHORT_TICKS   = 15,
  parameter int LONG_TICKS    = 253,
  parameter int TIMEOUT_TICKS = 1200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rts_i,
  input  logic loe_i,
  input  logic remote_i,
  input  logic rx_sync_i,
  input  logic carrier_mode_i,
  input  logic long_dly_i,
  input  logic train_done_i,
  output logic start_o,
  output logic rfs_o
);
  localparam int DLY_MAX = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int DW      = $clog2(DLY_MAX + 1);
  localparam int TW      = $clog2(TIMEOUT_TICKS + 1);

  logic [2:0]    rise, fall;
  logic [DW-1:0] dly_cnt, dly_tgt;
  logic [TW-1:0] tmr_cnt;
  rt_state_e     state;
  logic          nxt_idle, in_wait, idle, timeout, rfs_q;

  rt_edge_det #(.N(3)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i ({remote_i, rts_i, loe_i}),
    .rise_o(rise),
    .fall_o(fall)
  );

  rt_tick_cnt #(.MAX(DLY_MAX)) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (~rts_i),
    .tick_i(tick_i),
    .cnt_o (dly_cnt)
  );

  rt_tick_cnt #(.MAX(TIMEOUT_TICKS)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (~in_wait),
    .tick_i(tick_i),
    .cnt_o (tmr_cnt)
  );

  assign in_wait = (state == ST_WAIT);
  assign idle    = (state == ST_IDLE);
  assign timeout = in_wait & tick_i & (tmr_cnt == TW'(TIMEOUT_TICKS - 1));
  assign dly_tgt = long_dly_i ? DW'(LONG_TICKS) : DW'(SHORT_TICKS);

  rt_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .loe_rise_i  (rise[0]),
    .rts_rise_i  (rise[1]),
    .rem_rise_i  (rise[2]),
    .rem_fall_i  (fall[2]),
    .carrier_i   (carrier_mode_i),
    .rx_sync_i   (rx_sync_i),
    .train_done_i(train_done_i),
    .timeout_i   (timeout),
    .start_o     (start_o),
    .state_o     (state),
    .nxt_idle_o  (nxt_idle)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rfs_q <= 1'b0;
    else         rfs_q <= rts_i & (dly_cnt >= dly_tgt) & nxt_idle;
  end

  assign rfs_o = rfs_q;
endmodule

// File: rtl/retrain_ctrl_chk.sv
module retrain_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rts_i,
  input logic loe_i,
  input logic remote_i,
  input logic carrier_mode_i,
  input logic start_o,
  input logic rfs_o,
  input logic idle
);
  p_rfs_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rts_i |=> !rfs_o);

  p_rfs_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfs_o |-> idle);

  p_start_no_rfs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !rfs_o);

  p_loe_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && loe_i && !$past(loe_i)) |=> start_o);

  p_rts_carrier_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && carrier_mode_i && rts_i && !$past(rts_i)) |=> start_o);

  p_answer_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && remote_i && !$past(remote_i)) |=> start_o);

  p_start_leaves_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !idle);
endmodule

bind retrain_ctrl retrain_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rts_i         (rts_i),
  .loe_i         (loe_i),
  .remote_i      (remote_i),
  .carrier_mode_i(carrier_mode_i),
  .start_o       (start_o),
  .rfs_o         (rfs_o),
  .idle          (idle)
);

// File: tb/retrain_ctrl_bench.sv
module retrain_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SHORT      = 3;
  localparam int LONG       = 8;
  localparam int TOUT       = 10;
  localparam int TLEN       = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b1, rts = 1'b0, loe = 1'b0, remote = 1'b0, rx_sync = 1'b0;
  logic carrier = 1'b0, long_dly = 1'b0, done = 1'b0;
  logic start, rfs;

  int checks = 0, errors = 0, start_cnt = 0, gcnt = 0;
  bit gen_auto = 1'b0, finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  retrain_ctrl #(.SHORT_TICKS(SHORT), .LONG_TICKS(LONG), .TIMEOUT_TICKS(TOUT)) u_retrain_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rts_i(rts), .loe_i(loe),
    .remote_i(remote), .rx_sync_i(rx_sync), .carrier_mode_i(carrier),
    .long_dly_i(long_dly), .train_done_i(done), .start_o(start), .rfs_o(rfs)
  );

  function automatic int rfs_latency(bit lng);
    return (lng ? LONG : SHORT) + 1;
  endfunction

  function automatic bit rfs_allowed(bit rts_before, bit start_now);
    return rts_before && !start_now;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (start) start_cnt++;
    if (gen_auto) begin
      done = 1'b0;
      if (start) gcnt = TLEN;
      else if (gcnt > 0) begin
        gcnt--;
        if (gcnt == 0) done = 1'b1;
      end
    end
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse_done();
    done = 1'b1; step(); done = 1'b0;
  endtask

  initial begin
    int base;
    bit rts_prev;
    steps(3);
    rst_n = 1'b1;
    step();
    // R1
    check(start == 0, "R1 start", start, 0);
    check(rfs == 0, "R1 rfs", rfs, 0);

    // R9 short delay, R3 no start in non-carrier mode
    base = start_cnt; rts = 1'b1;
    steps(rfs_latency(0) - 1);
    check(rfs == 0, "R9 short early", rfs, 0);
    step();
    check(rfs == 1, "R9 short on", rfs, 1);
    check(start_cnt == base, "R3 no start non-carrier", start_cnt, base);
    rts = 1'b0; step();
    check(rfs == 0, "R10 drop", rfs, 0);

    // R9 long delay
    long_dly = 1'b1; rts = 1'b1;
    steps(rfs_latency(1) - 1);
    check(rfs == 0, "R9 long early", rfs, 0);
    step();
    check(rfs == 1, "R9 long on", rfs, 1);
    rts = 1'b0; step();

    // R3 carrier mode start, R8 rfs off during training
    carrier = 1'b1; rts = 1'b1; base = start_cnt; step();
    check(start == 1, "R3 carrier start", start, 1);
    check(rfs == 0, "R8 rfs at start", rfs, 0);
    step(); pulse_done();
    steps(rfs_latency(1) - 4);
    check(rfs == 0, "R9 carrier early", rfs, 0);
    step();
    check(rfs == 1, "R9 carrier on", rfs, 1);
    check(start_cnt == base + 1, "R3 single start", start_cnt, base + 1);
    rts = 1'b0; carrier = 1'b0; long_dly = 1'b0; step();

    // R2 loe start, R5 timeout retry, R12 loe during training, R7 close
    loe = 1'b1; base = start_cnt; step();
    check(start == 1, "R2 loe start", start, 1);
    loe = 1'b0; step(); loe = 1'b1; step();
    check(start_cnt == base + 1, "R12 no extra start", start_cnt, base + 1);
    rts = 1'b1; step();
    check(rfs == 0, "R8 rfs in training", rfs, 0);
    rts = 1'b0;
    pulse_done();
    steps(TOUT - 1);
    check(start_cnt == base + 1, "R5 before timeout", start_cnt, base + 1);
    step();
    check(start == 1, "R5 timeout retry", start, 1);
    remote = 1'b1; step(); rx_sync = 1'b1; remote = 1'b0; step();
    pulse_done();
    steps(TOUT + 5);
    check(start_cnt == base + 2, "R7 closed after sync", start_cnt, base + 2);
    loe = 1'b0; rx_sync = 1'b0; step();

    // R4 answer with rts high, R7 exactly one
    rts = 1'b1; remote = 1'b1; base = start_cnt; step();
    check(start == 1, "R4 answer start", start, 1);
    rx_sync = 1'b1; remote = 1'b0; step();
    pulse_done();
    steps(TOUT + 5);
    check(start_cnt == base + 1, "R7 one answer", start_cnt, base + 1);
    rts = 1'b0; rx_sync = 1'b0; step();

    // R6 failed sync retry
    remote = 1'b1; base = start_cnt; step();
    remote = 1'b0; step();
    pulse_done();
    check(start == 1, "R6 fail retry", start, 1);
    remote = 1'b1; step(); rx_sync = 1'b1; remote = 1'b0; step();
    pulse_done(); steps(TOUT + 5);
    check(start_cnt == base + 2, "R6 total starts", start_cnt, base + 2);
    rx_sync = 1'b0; step();

    // R11 done and failed remote end in same cycle
    loe = 1'b1; base = start_cnt; step();
    remote = 1'b1; step();
    done = 1'b1; remote = 1'b0; rx_sync = 1'b0; step(); done = 1'b0;
    check(start == 1, "R11 same-cycle restart", start, 1);
    remote = 1'b1; step(); rx_sync = 1'b1; remote = 1'b0; step();
    pulse_done(); steps(TOUT + 5);
    check(start_cnt == base + 2, "R11 total starts", start_cnt, base + 2);
    loe = 1'b0; rx_sync = 1'b0; step();

    // constrained random with auto training generator
    void'($urandom(32'd2024));
    gen_auto = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(39, 0) == 0) rts = ~rts;
      if ($urandom_range(59, 0) == 0) loe = ~loe;
      if ($urandom_range(29, 0) == 0) remote = ~remote;
      if ($urandom_range(199, 0) == 0) carrier = ~carrier;
      if ($urandom_range(199, 0) == 0) long_dly = ~long_dly;
      rx_sync = ($urandom_range(3, 0) != 0);
      tick = $urandom_range(1, 0);
      rts_prev = rts;
      step();
      if (!rfs_allowed(rts_prev, start))
        check(rfs == 0, "R10/R8 random rfs", rfs, 0);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule